// File: doc/BRIEF.md
# Outbound Memory Window Decoder

This block sits in a host-to-PCI bridge and decides, for every CPU-side address, whether the bridge should claim it and forward it into PCI memory space. The region that starts at 0xF0000000 is split into 8 MiB slots. Slots 1 to 30 are usable windows. Each window is gated by its own bit in an enable bitmap, and all windows are gated together by a two-bit field in a control word that must hold one specific code. A claimed address goes through unchanged, because each window maps one-to-one onto the same PCI memory address.

The block also sorts bus-master (inbound) addresses. An inbound address goes either to system RAM or back into PCI memory space. A small register port holds the control word and the enable bitmap. Both outputs, the outbound decode and the inbound route, are computed combinationally and registered once before they leave the block.

Top module: `obwin_decoder`

## Requirements
- R1: After reset, the control register and the enable register both read as zero, and no outbound request is claimed.
- R2: A write to byte offset 0x060 stores the write data ANDed with 0x7FFFFFFE, so bits 0 and 31 read back as zero. A write to byte offset 0x038 stores the full word. Reads at these two offsets return the stored values. Any other offset reads as zero, and a write to it changes neither register.
- R3: Forwarding is globally on only when control bits [8:7] equal 2'b01. With any other value in those bits (00, 10, 11), no address is claimed, whatever the enable bitmap holds.
- R4: Window i, for i from 1 to 30, covers 0xF0000000 + i*0x00800000 up to 0x007FFFFF above that. An address in window i is claimed only when forwarding is on and enable bit i is set. Addresses below 0xF0800000 and addresses at or above 0xFF800000 are never claimed.
- R5: An outbound request presented in one cycle gives its result one clock later. When the request is claimed, the result shows the hit flag high, the window index, and a PCI address equal to the request address. When it is not claimed, the hit flag, the index and the PCI address are all zero.
- R6: A register write takes effect on a request presented in the cycle after the write. A request presented in the same cycle as the write is decoded with the old value.
- R7: An inbound address below 0xF0800000 routes to system RAM. An inbound address from 0xF0800000 through 0xFFFFFFFF (31 windows of 8 MiB) routes to PCI memory. A valid inbound request raises exactly one of the two route flags, one clock later.
- R8: When a request-valid input is low, the matching registered outputs are low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| ob_valid | input | 1 | Outbound request valid |
| ob_addr | input | 32 | Outbound CPU-side address |
| ob_valid_q | output | 1 | Registered outbound valid |
| ob_hit_q | output | 1 | Address claimed for PCI forwarding |
| ob_win_q | output | 5 | Index of the window that matched |
| ob_pci_addr_q | output | 32 | PCI memory address that is forwarded |
| ib_valid | input | 1 | Inbound bus-master request valid |
| ib_addr | input | 32 | Inbound address |
| ib_ram_q | output | 1 | Inbound address routes to system RAM |
| ib_pci_q | output | 1 | Inbound address routes to PCI memory |

## Verification
The bench sweeps the first and last byte of all 32 slots. A decoder that is off by one slot, or that lets slot 0 or slot 31 claim, fails at those edges. It writes all ones to the enable register to show that bits 0 and 31 are dropped, and it steps through all four gate codes, including 01 with every other control bit set, to catch a gate that looks at the wrong bits or the whole word. A register write followed at once by a request, and a request made in the same cycle as a write, show whether the new value applies one cycle too early or too late. Inbound addresses on both sides of 0xF0800000 show an off-by-one at the RAM/PCI split.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

   // Route classes for an inbound bus-master address
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'b00,
      ROUTE_RAM  = 2'b01,
      ROUTE_PCI  = 2'b10
   } ib_route_e;

   // True when an offset lies inside a closed range
   function automatic logic in_span(input int idx, input int lo, input int hi);
      return (idx >= lo) && (idx <= hi);
   endfunction

endpackage

// File: rtl/obwin_regs.sv
module obwin_regs #(
   parameter int                  DATA_W   = 32,
   parameter int                  REG_AW   = 12,
   parameter logic [REG_AW-1:0]   CTRL_OFS = 12'h038,
   parameter logic [REG_AW-1:0]   EN_OFS   = 12'h060,
   parameter logic [DATA_W-1:0]   EN_MASK  = 32'h7FFF_FFFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_AW-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] en_q
);

   if (CTRL_OFS == EN_OFS) begin : g_bad_ofs
      $error("obwin_regs: register offsets collide");
   end

   logic sel_ctrl, sel_en;
   assign sel_ctrl = (addr == CTRL_OFS);
   assign sel_en   = (addr == EN_OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         en_q   <= '0;
      end else if (wr) begin
         if (sel_ctrl) ctrl_q <= wdata;
         if (sel_en)   en_q   <= wdata & EN_MASK;
      end
   end

   always_comb begin
      rdata = '0;
      if (sel_ctrl) rdata = ctrl_q;
      if (sel_en)   rdata = en_q;
   end

   // R2: masked bits stay clear after a bitmap write
   p_en_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel_en) |=> ((en_q & ~EN_MASK) == '0));

   // R2: a write elsewhere leaves both registers untouched
   p_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !sel_ctrl && !sel_en) |=> ($stable(ctrl_q) && $stable(en_q)));

endmodule

// File: rtl/obwin_outbound.sv
module obwin_outbound
   import obwin_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter int                WIN_SHIFT = 23,
   parameter int                IDX_W     = 5,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 32'hF000_0000,
   parameter int                WIN_FIRST = 1,
   parameter int                WIN_LAST  = 30,
   parameter int                GATE_W    = 2,
   parameter logic [GATE_W-1:0] GATE_CODE = 2'b01
) (
   input  logic [GATE_W-1:0]          gate_field,
   input  logic [DATA_W-1:0]          en_map,
   input  logic [ADDR_W-1:WIN_SHIFT]  page,
   output logic                       hit,
   output logic [IDX_W-1:0]           win
);

   localparam int SLOTS   = 1 << IDX_W;
   localparam int TAG_LSB = WIN_SHIFT + IDX_W;

   if (TAG_LSB >= ADDR_W) begin : g_bad_tag
      $error("obwin_outbound: no address bits left for the region tag");
   end
   if (WIN_FIRST > WIN_LAST || WIN_LAST >= SLOTS || WIN_LAST >= DATA_W) begin : g_bad_span
      $error("obwin_outbound: window span does not fit slots or bitmap");
   end

   logic                       gate_on;
   logic                       tag_match;
   logic [IDX_W-1:0]           slot;
   logic [SLOTS-1:0]           open;

   assign gate_on   = (gate_field == GATE_CODE);
   assign tag_match = (page[ADDR_W-1:TAG_LSB] == WIN_BASE[ADDR_W-1:TAG_LSB]);
   assign slot      = page[TAG_LSB-1:WIN_SHIFT];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (s < DATA_W && in_span(s, WIN_FIRST, WIN_LAST)) begin : g_live
         assign open[s] = gate_on & en_map[s];
      end else begin : g_dead
         assign open[s] = 1'b0;
      end
   end

   assign hit = tag_match & open[slot];
   assign win = hit ? slot : '0;

endmodule

// File: rtl/obwin_inbound.sv
module obwin_inbound
   import obwin_pkg::*;
#(
   parameter int                ADDR_W        = 32,
   parameter int                WIN_SHIFT     = 23,
   parameter logic [ADDR_W-1:0] WIN_BASE      = 32'hF000_0000,
   parameter int                PCI_SPAN_WINS = 31
) (
   input  logic [ADDR_W-1:0] addr,
   output ib_route_e         route
);

   localparam logic [ADDR_W:0] WIN_SZ  = {{ADDR_W{1'b0}}, 1'b1} << WIN_SHIFT;
   localparam logic [ADDR_W:0] SPLIT   = {1'b0, WIN_BASE} + WIN_SZ;
   localparam logic [ADDR_W:0] PCI_TOP = SPLIT + WIN_SZ * PCI_SPAN_WINS;

   if (PCI_SPAN_WINS < 1) begin : g_bad_span
      $error("obwin_inbound: PCI loop-back span must hold a window");
   end

   logic [ADDR_W:0] a_ext;
   assign a_ext = {1'b0, addr};

   always_comb begin
      if (a_ext < SPLIT)         route = ROUTE_RAM;
      else if (a_ext < PCI_TOP)  route = ROUTE_PCI;
      else                       route = ROUTE_NONE;
   end

endmodule

// File: rtl/obwin_decoder.sv
module obwin_decoder
   import obwin_pkg::*;
#(
   parameter int                ADDR_W        = 32,
   parameter int                DATA_W        = 32,
   parameter int                REG_AW        = 12,
   parameter int                WIN_SHIFT     = 23,
   parameter int                IDX_W         = 5,
   parameter logic [ADDR_W-1:0] WIN_BASE      = 32'hF000_0000,
   parameter int                WIN_FIRST     = 1,
   parameter int                WIN_LAST      = 30,
   parameter int                PCI_SPAN_WINS = 31,
   parameter int                GATE_LSB      = 7,
   parameter int                GATE_W        = 2,
   parameter logic [GATE_W-1:0] GATE_CODE     = 2'b01,
   parameter logic [REG_AW-1:0] CTRL_OFS      = 12'h038,
   parameter logic [REG_AW-1:0] EN_OFS        = 12'h060,
   parameter logic [DATA_W-1:0] EN_MASK       = 32'h7FFF_FFFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              ob_valid,
   input  logic [ADDR_W-1:0] ob_addr,
   output logic              ob_valid_q,
   output logic              ob_hit_q,
   output logic [IDX_W-1:0]  ob_win_q,
   output logic [ADDR_W-1:0] ob_pci_addr_q,
   input  logic              ib_valid,
   input  logic [ADDR_W-1:0] ib_addr,
   output logic              ib_ram_q,
   output logic              ib_pci_q
);

   if (GATE_LSB + GATE_W > DATA_W) begin : g_bad_gate
      $error("obwin_decoder: gate field lies outside the control word");
   end

   logic [DATA_W-1:0] ctrl_q, en_q;
   logic [GATE_W-1:0] gate_field;
   logic              dec_hit;
   logic [IDX_W-1:0]  dec_win;
   ib_route_e         route;

   obwin_regs #(
      .DATA_W(DATA_W), .REG_AW(REG_AW), .CTRL_OFS(CTRL_OFS),
      .EN_OFS(EN_OFS), .EN_MASK(EN_MASK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .ctrl_q(ctrl_q), .en_q(en_q)
   );

   assign gate_field = ctrl_q[GATE_LSB +: GATE_W];

   obwin_outbound #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_SHIFT(WIN_SHIFT), .IDX_W(IDX_W),
      .WIN_BASE(WIN_BASE), .WIN_FIRST(WIN_FIRST), .WIN_LAST(WIN_LAST),
      .GATE_W(GATE_W), .GATE_CODE(GATE_CODE)
   ) u_out (
      .gate_field(gate_field), .en_map(en_q),
      .page(ob_addr[ADDR_W-1:WIN_SHIFT]), .hit(dec_hit), .win(dec_win)
   );

   obwin_inbound #(
      .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .WIN_BASE(WIN_BASE),
      .PCI_SPAN_WINS(PCI_SPAN_WINS)
   ) u_in (
      .addr(ib_addr), .route(route)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ob_valid_q    <= 1'b0;
         ob_hit_q      <= 1'b0;
         ob_win_q      <= '0;
         ob_pci_addr_q <= '0;
         ib_ram_q      <= 1'b0;
         ib_pci_q      <= 1'b0;
      end else begin
         ob_valid_q    <= ob_valid;
         ob_hit_q      <= ob_valid & dec_hit;
         ob_win_q      <= (ob_valid & dec_hit) ? dec_win : '0;
         ob_pci_addr_q <= (ob_valid & dec_hit) ? ob_addr : '0;
         ib_ram_q      <= ib_valid & (route == ROUTE_RAM);
         ib_pci_q      <= ib_valid & (route == ROUTE_PCI);
      end
   end

   // R3: a claim needs the gate code in the control word of the decode cycle
   p_gate_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ob_hit_q |-> ($past(ctrl_q[GATE_LSB +: GATE_W]) == GATE_CODE));

   // R4: a claim always names a usable window
   p_win_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ob_hit_q |-> (int'(ob_win_q) >= WIN_FIRST && int'(ob_win_q) <= WIN_LAST));

   // R5: the forwarded address is the request address, unchanged
   p_addr_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ob_hit_q |-> (ob_pci_addr_q == $past(ob_addr)));

   // R7: a valid inbound request takes exactly one route
   p_route_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ib_valid) |-> $countones({ib_ram_q, ib_pci_q}) == 1);

   // R8: no claim without a valid request
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ob_valid_q |-> !ob_hit_q);

endmodule

// File: tb/tb_obwin_decoder.sv
module tb_obwin_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        ob_valid = 1'b0;
   logic [31:0] ob_addr = '0;
   logic        ob_valid_q, ob_hit_q;
   logic [4:0]  ob_win_q;
   logic [31:0] ob_pci_addr_q;
   logic        ib_valid = 1'b0;
   logic [31:0] ib_addr = '0;
   logic        ib_ram_q, ib_pci_q;

   always #5 clk = ~clk;

   obwin_decoder dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ob_valid(ob_valid),
      .ob_addr(ob_addr), .ob_valid_q(ob_valid_q), .ob_hit_q(ob_hit_q),
      .ob_win_q(ob_win_q), .ob_pci_addr_q(ob_pci_addr_q), .ib_valid(ib_valid),
      .ib_addr(ib_addr), .ib_ram_q(ib_ram_q), .ib_pci_q(ib_pci_q)
   );

   int    errors = 0;
   int    checks = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // Behavioural reference state
   logic [31:0] m_ctrl = '0, m_en = '0;
   logic        e_valid = 0, e_hit = 0, e_ram = 0, e_pci = 0;
   logic [4:0]  e_win = '0;
   logic [31:0] e_paddr = '0;

   function automatic bit model_claims(logic [31:0] a, logic [31:0] c, logic [31:0] e, output int idx);
      idx = 0;
      if (a < 32'hF000_0000) return 0;
      idx = int'((a - 32'hF000_0000) / 32'h0080_0000);
      if (idx < 1 || idx > 30) return 0;
      if (c[8:7] != 2'b01) return 0;
      return e[idx];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl <= '0; m_en <= '0;
         e_valid <= 0; e_hit <= 0; e_win <= '0; e_paddr <= '0; e_ram <= 0; e_pci <= 0;
      end else begin
         int  w;
         bit  c;
         c = ob_valid && model_claims(ob_addr, m_ctrl, m_en, w);
         e_valid <= ob_valid;
         e_hit   <= c;
         e_win   <= c ? 5'(w) : 5'd0;
         e_paddr <= c ? ob_addr : 32'd0;
         e_ram   <= ib_valid && (ib_addr < 32'hF080_0000);
         e_pci   <= ib_valid && (ib_addr >= 32'hF080_0000);
         if (cfg_wr && cfg_addr == 12'h038) m_ctrl <= cfg_wdata;
         if (cfg_wr && cfg_addr == 12'h060) m_en   <= cfg_wdata & 32'h7FFF_FFFE;
      end
   end

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         logic [31:0] e_rd;
         e_rd = (cfg_addr == 12'h038) ? m_ctrl : (cfg_addr == 12'h060) ? m_en : 32'd0;
         chk("rdata", cfg_rdata, e_rd);
         chk("ob_valid_q", 32'(ob_valid_q), 32'(e_valid));
         chk("ob_hit_q", 32'(ob_hit_q), 32'(e_hit));
         chk("ob_win_q", 32'(ob_win_q), 32'(e_win));
         chk("ob_pci_addr_q", ob_pci_addr_q, e_paddr);
         chk("ib_ram_q", 32'(ib_ram_q), 32'(e_ram));
         chk("ib_pci_q", 32'(ib_pci_q), 32'(e_pci));
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr_reg(logic [11:0] a, logic [31:0] d);
      cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
      step();
      cfg_wr = 0;
   endtask

   task automatic ob_req(logic [31:0] a);
      ob_valid = 1; ob_addr = a;
      step();
      ob_valid = 0;
   endtask

   task automatic ib_req(logic [31:0] a);
      ib_valid = 1; ib_addr = a;
      step();
      ib_valid = 0;
   endtask

   task automatic summary();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      ob_valid = 1; ob_addr = 32'hF080_0000;
      repeat (3) step();
      rst_n = 1'b1;
      cfg_addr = 12'h038; step();
      cfg_addr = 12'h060; step();
      ob_req(32'hF080_0000);
      ob_valid = 0; step();

      // R2: masking, readback, stray writes
      cur_req = "R2";
      wr_reg(12'h060, 32'hFFFF_FFFF);
      cfg_addr = 12'h060; step();
      wr_reg(12'h038, 32'h0000_0080);
      cfg_addr = 12'h038; step();
      wr_reg(12'h040, 32'hDEAD_BEEF);
      cfg_addr = 12'h040; step();
      cfg_addr = 12'h038; step();
      cfg_addr = 12'h060; step();

      // R4: sweep both edges of every slot, plus far addresses
      cur_req = "R4";
      for (int i = 0; i < 32; i++) begin
         ob_req(32'hF000_0000 + i * 32'h0080_0000);
         ob_req(32'hF000_0000 + i * 32'h0080_0000 + 32'h007F_FFFF);
      end
      ob_req(32'hEFFF_FFFF);
      ob_req(32'h0000_1000);
      wr_reg(12'h060, 32'h0000_0404);
      for (int i = 0; i < 32; i++) ob_req(32'hF000_0000 + i * 32'h0080_0000 + 32'h40);

      // R3: all gate codes
      cur_req = "R3";
      wr_reg(12'h060, 32'h7FFF_FFFE);
      wr_reg(12'h038, 32'h0000_0000); ob_req(32'hF100_0000);
      wr_reg(12'h038, 32'h0000_0100); ob_req(32'hF100_0000);
      wr_reg(12'h038, 32'h0000_0180); ob_req(32'hF100_0000);
      wr_reg(12'h038, 32'hFFFF_FEFF); ob_req(32'hF100_0000);
      wr_reg(12'h038, 32'h0000_0080); ob_req(32'hF100_0000);

      // R5: result timing and passthrough on back-to-back requests
      cur_req = "R5";
      ob_valid = 1;
      ob_addr = 32'hF123_4567; step();
      ob_addr = 32'hFF7F_FFFC; step();
      ob_addr = 32'h1234_5678; step();
      ob_valid = 0; step();

      // R6: same-cycle and next-cycle effect of a write
      cur_req = "R6";
      cfg_wr = 1; cfg_addr = 12'h060; cfg_wdata = 32'h0000_0002;
      ob_valid = 1; ob_addr = 32'hF180_0000;
      step();
      cfg_wr = 0;
      step();
      cfg_wr = 1; cfg_addr = 12'h038; cfg_wdata = 32'h0;
      ob_addr = 32'hF100_0000;
      step();
      cfg_wr = 0;
      step();
      ob_valid = 0; step();

      // R7: inbound split
      cur_req = "R7";
      ib_req(32'h0000_0000);
      ib_req(32'h8000_0000);
      ib_req(32'hF07F_FFFF);
      ib_req(32'hF080_0000);
      ib_req(32'hFFFF_FFFF);

      // R8: invalid requests produce nothing
      cur_req = "R8";
      wr_reg(12'h038, 32'h0000_0080);
      ob_valid = 0; ob_addr = 32'hF100_0000;
      ib_valid = 0; ib_addr = 32'hF100_0000;
      step(); step();

      summary();
   end

endmodule